// File: doc/BRIEF.md
# Bus Watchpoint and Single-Step Trap Unit

This block sits beside an 8-bit microcontroller core and watches two of its buses. The first is the program fetch address. The second is the data-memory bus, with its address, data, strobe and write/read direction. When a programmed condition matches, the block raises a debug interrupt request for one clock cycle. In single-step mode it raises one request for each instruction-complete strobe from the core.

A debugger programs the block through an index/data pair. An index write selects one of four registers, and a data write loads the selected register. `cfg_rdata` always shows the selected register.
- Index 0 is the mode byte.
- Index 1 is the data mask.
- Index 2 is the compare low byte. It holds the fetch address low byte or the memory address.
- Index 3 is the compare high byte. It holds the fetch address high byte or the memory data value.

Reading the mode register also reports whether the last memory trap came from a write or from a read.

The control state machine has four states:
- `ST_OFF`: the mode is zero.
- `ST_WATCH`: compares are armed.
- `ST_STEP`: single-step is armed.
- `ST_FIRE`: the request is being driven.

On every cycle the next state is chosen in this order:
1. `ST_OFF` when the mode byte is zero.
2. Otherwise `ST_FIRE` when a trap event is seen in the current cycle.
3. Otherwise `ST_STEP` when the mode byte has bit 7 set, else `ST_WATCH`.

Any state can reach any other state.

Top module: `bus_watch_trap`

## Requirements
- R1: After reset `dbg_irq` is 0 and all four registers (indices 0 to 3) read 0.
- R2: An index write takes `cfg_wdata[1:0]` as the index. Registers 1 to 3 read back exactly as written. Register 0 reads back bits 0 to 4 and bit 7 as written.
- R3: When mode bit 0 is set and `fetch_vld` is high with `fetch_addr` equal to {reg3, reg2}, `dbg_irq` is high in the next cycle. A different address, or `fetch_vld` low, gives no request.
- R4: A memory compare counts only in a cycle with `mem_stb` high. It also needs either mode bit 3 set with `mem_we`=1 (write), or mode bit 4 set with `mem_we`=0 (read). When mode bit 1 is set, `mem_addr` must equal reg2.
- R5: When mode bit 2 is set, the compare requires (`mem_data` AND reg1) to equal (reg3 AND reg1). A mask bit of 1 takes part in the compare and a 0 bit is ignored.
- R6: When mode bits 1 and 2 are both set, both the address and the data must match for a trap.
- R7: A memory trap caused by a write sets mode read-back bit 5, and one caused by a read sets bit 6. Both flags stay set until the next data write to register 0, which clears them.
- R8: When mode bit 7 is set, each cycle with `insn_done` high gives `dbg_irq` high in the following cycle.
- R9: With mode 00h no bus activity or `insn_done` produces a request.
- R10: `dbg_irq` is high for exactly one cycle per trap cycle. It is low in the cycle after a cycle with no trap event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_idx_we | input | 1 | Load register index from cfg_wdata[1:0] |
| cfg_dat_we | input | 1 | Load selected register from cfg_wdata |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected register read data |
| fetch_vld | input | 1 | Fetch address valid |
| fetch_addr | input | 16 | Program fetch address |
| mem_stb | input | 1 | Data-memory access strobe |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 8 | Data-memory address |
| mem_data | input | 8 | Data-memory data |
| insn_done | input | 1 | Instruction-complete strobe |
| dbg_irq | output | 1 | Debug interrupt request, one cycle per trap |

## Verification
A wrong state or a corrupted compare register in this block shows up at `dbg_irq` exactly one cycle after the bus cycle that should have trapped. That cycle shows either a missing pulse or a spurious one, so the scoreboard compares every driven cycle against its own prediction.

Corrupted cause flags show at `cfg_rdata` on the next mode read. Reads are placed straight after read-side and write-side traps, and again after a mode rewrite.

The single-step tests use back-to-back strobes. A state machine that stays in its fire state, or that drops a pulse, therefore differs from the prediction within one cycle.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_STEP  = 2'd2,
        ST_FIRE  = 2'd3
    } bwt_state_e;

    localparam int IDX_MODE = 0;
    localparam int IDX_MASK = 1;
    localparam int IDX_LO   = 2;
    localparam int IDX_HI   = 3;

    localparam int MB_ROM   = 0;
    localparam int MB_MADDR = 1;
    localparam int MB_MDATA = 2;
    localparam int MB_QWR   = 3;
    localparam int MB_QRD   = 4;
    localparam int MB_FWR   = 5;
    localparam int MB_FRD   = 6;
    localparam int MB_STEP  = 7;
endpackage

// File: rtl/bwt_regs.sv
module bwt_regs
    import bwt_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_idx_we,
    input  logic          cfg_dat_we,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          flag_wr,
    input  logic          flag_rd,
    output logic [DW-1:0] cfg_rdata,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] lo_q,
    output logic [DW-1:0] hi_q,
    output logic          mode_wr
);
    localparam int IW = $clog2(NREG);

    logic [IW-1:0] idx_q;
    logic [DW-1:0] reg_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (cfg_idx_we) begin
            idx_q <= cfg_wdata[IW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) reg_q[i] <= '0;
        end else if (cfg_dat_we) begin
            for (int i = 0; i < NREG; i++) begin
                if (idx_q == IW'(i)) reg_q[i] <= cfg_wdata;
            end
        end
    end

    assign mode_wr = cfg_dat_we && (idx_q == IW'(IDX_MODE));
    assign mode_q  = reg_q[IDX_MODE];
    assign mask_q  = reg_q[IDX_MASK];
    assign lo_q    = reg_q[IDX_LO];
    assign hi_q    = reg_q[IDX_HI];

    always_comb begin
        cfg_rdata = reg_q[idx_q];
        if (idx_q == IW'(IDX_MODE)) begin
            cfg_rdata[MB_FWR] = flag_wr;
            cfg_rdata[MB_FRD] = flag_rd;
        end
    end

    // R2: a data write lands in the selected register on the next cycle
    p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dat_we && !cfg_idx_we && idx_q == IW'(IDX_MASK)) |=> (mask_q == $past(cfg_wdata)));
endmodule

// File: rtl/bwt_match.sv
module bwt_match #(
    parameter int DW = 8
) (
    input  logic            en_rom,
    input  logic            en_maddr,
    input  logic            en_mdata,
    input  logic            q_wr,
    input  logic            q_rd,
    input  logic            en_step,
    input  logic [DW-1:0]   mask_q,
    input  logic [DW-1:0]   lo_q,
    input  logic [DW-1:0]   hi_q,
    input  logic            fetch_vld,
    input  logic [2*DW-1:0] fetch_addr,
    input  logic            mem_stb,
    input  logic            mem_we,
    input  logic [DW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_data,
    input  logic            insn_done,
    output logic            hit,
    output logic            hit_wr,
    output logic            hit_rd
);
    logic rom_hit;
    logic mem_qual;
    logic addr_ok;
    logic data_ok;
    logic mem_hit;
    logic step_hit;

    always_comb begin
        rom_hit  = en_rom && fetch_vld && (fetch_addr == {hi_q, lo_q});
        mem_qual = mem_stb && ((mem_we && q_wr) || (!mem_we && q_rd));
        addr_ok  = !en_maddr || (mem_addr == lo_q);
        data_ok  = !en_mdata || (((mem_data ^ hi_q) & mask_q) == '0);
        mem_hit  = mem_qual && (en_maddr || en_mdata) && addr_ok && data_ok;
        step_hit = en_step && insn_done;
        hit      = rom_hit || mem_hit || step_hit;
        hit_wr   = mem_hit && mem_we;
        hit_rd   = mem_hit && !mem_we;
    end
endmodule

// File: rtl/bwt_fsm.sv
module bwt_fsm
    import bwt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mode_q,
    input  logic          mode_wr,
    input  logic          hit,
    input  logic          hit_wr,
    input  logic          hit_rd,
    output logic          dbg_irq,
    output logic          flag_wr,
    output logic          flag_rd
);
    bwt_state_e state_q;
    bwt_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_OFF, ST_WATCH, ST_STEP, ST_FIRE: begin
                if (mode_q == '0)       state_d = ST_OFF;
                else if (hit)           state_d = ST_FIRE;
                else if (mode_q[MB_STEP]) state_d = ST_STEP;
                else                    state_d = ST_WATCH;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        dbg_irq = (state_q == ST_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_wr <= 1'b0;
            flag_rd <= 1'b0;
        end else if (mode_wr) begin
            flag_wr <= 1'b0;
            flag_rd <= 1'b0;
        end else begin
            flag_wr <= flag_wr | hit_wr;
            flag_rd <= flag_rd | hit_rd;
        end
    end

    // R10: every request cycle follows a trap event
    p_irq_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq |-> $past(hit));
    // R7: a cause flag only rises together with a request
    p_flag_with_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_wr) || $rose(flag_rd)) |-> dbg_irq);
    // R7: rewriting the mode clears both cause flags
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (!flag_wr && !flag_rd));
    // R9: a zero mode never produces a request
    p_off_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == '0) |=> !dbg_irq);
endmodule

// File: rtl/bus_watch_trap.sv
module bus_watch_trap
    import bwt_pkg::*;
#(
    parameter int DW = 8,
    localparam int FAW = 2 * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_idx_we,
    input  logic           cfg_dat_we,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    input  logic           fetch_vld,
    input  logic [FAW-1:0] fetch_addr,
    input  logic           mem_stb,
    input  logic           mem_we,
    input  logic [DW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_data,
    input  logic           insn_done,
    output logic           dbg_irq
);
    logic [DW-1:0] mode_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;
    logic          mode_wr;
    logic          flag_wr;
    logic          flag_rd;
    logic          hit;
    logic          hit_wr;
    logic          hit_rd;

    bwt_regs #(.DW(DW), .NREG(4)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_idx_we(cfg_idx_we), .cfg_dat_we(cfg_dat_we), .cfg_wdata(cfg_wdata),
        .flag_wr(flag_wr), .flag_rd(flag_rd), .cfg_rdata(cfg_rdata),
        .mode_q(mode_q), .mask_q(mask_q), .lo_q(lo_q), .hi_q(hi_q),
        .mode_wr(mode_wr)
    );

    bwt_match #(.DW(DW)) match_i (
        .en_rom(mode_q[MB_ROM]), .en_maddr(mode_q[MB_MADDR]),
        .en_mdata(mode_q[MB_MDATA]), .q_wr(mode_q[MB_QWR]),
        .q_rd(mode_q[MB_QRD]), .en_step(mode_q[MB_STEP]),
        .mask_q(mask_q), .lo_q(lo_q), .hi_q(hi_q),
        .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
        .mem_stb(mem_stb), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .insn_done(insn_done),
        .hit(hit), .hit_wr(hit_wr), .hit_rd(hit_rd)
    );

    bwt_fsm #(.DW(DW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .mode_wr(mode_wr),
        .hit(hit), .hit_wr(hit_wr), .hit_rd(hit_rd),
        .dbg_irq(dbg_irq), .flag_wr(flag_wr), .flag_rd(flag_rd)
    );

    // R8: every instruction-complete strobe in step mode yields a request
    p_step_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[MB_STEP] && insn_done) |=> dbg_irq);
    // R4: a memory access without its qualifier bit cannot trap by itself
    p_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && mem_we && !mode_q[MB_QWR] && !mode_q[MB_ROM] && !mode_q[MB_STEP]) |=> !dbg_irq);
endmodule

// File: tb/bus_watch_trap_tb_top.sv
module bus_watch_trap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_idx_we = 1'b0;
    logic        cfg_dat_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        fetch_vld = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        mem_stb = 1'b0;
    logic        mem_we = 1'b0;
    logic [7:0]  mem_addr = '0;
    logic [7:0]  mem_data = '0;
    logic        insn_done = 1'b0;
    logic        dbg_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  irq;
        int    stamp;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t mon_e;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_watch_trap dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_idx_we(cfg_idx_we), .cfg_dat_we(cfg_dat_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fetch_vld(fetch_vld),
        .fetch_addr(fetch_addr), .mem_stb(mem_stb), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .insn_done(insn_done),
        .dbg_irq(dbg_irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares dbg_irq one cycle after each driven cycle
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].stamp < cyc) begin
            mon_e = exp_q.pop_front();
            chk({7'd0, dbg_irq}, {7'd0, mon_e.irq}, mon_e.tag);
        end
    end

    task automatic step(input logic fv, input logic [15:0] fa, input logic ms,
                        input logic mw, input logic [7:0] ma, input logic [7:0] md,
                        input logic id, input logic ex, input string tag);
        exp_t e;
        @(posedge clk); #1;
        cfg_idx_we = 1'b0; cfg_dat_we = 1'b0;
        fetch_vld = fv; fetch_addr = fa; mem_stb = ms; mem_we = mw;
        mem_addr = ma; mem_data = md; insn_done = id;
        e.irq = ex; e.stamp = cyc; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 16'h0, 1'b0, 1'b0, 8'h0, 8'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic cfg_cycle(input logic iw, input logic dw, input logic [7:0] v);
        exp_t e;
        @(posedge clk); #1;
        fetch_vld = 1'b0; mem_stb = 1'b0; insn_done = 1'b0;
        cfg_idx_we = iw; cfg_dat_we = dw; cfg_wdata = v;
        e.irq = 1'b0; e.stamp = cyc; e.tag = "cfg cycle";
        exp_q.push_back(e);
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
        cfg_cycle(1'b1, 1'b0, idx);
        cfg_cycle(1'b0, 1'b1, v);
    endtask

    task automatic rd_chk(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        cfg_cycle(1'b1, 1'b0, idx);
        @(posedge clk); #1;
        cfg_idx_we = 1'b0;
        @(negedge clk);
        chk(cfg_rdata, exp, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({7'd0, dbg_irq}, 8'h0, "R1 irq in reset");
        rst_n = 1'b1;
        rd_chk(8'd0, 8'h00, "R1 mode reset");
        rd_chk(8'd1, 8'h00, "R1 mask reset");
        rd_chk(8'd2, 8'h00, "R1 lo reset");
        rd_chk(8'd3, 8'h00, "R1 hi reset");

        // R2 register access, R3 fetch address match
        set_reg(8'd1, 8'hFF);
        set_reg(8'd2, 8'h34);
        set_reg(8'd3, 8'h12);
        set_reg(8'd0, 8'h01);
        rd_chk(8'd1, 8'hFF, "R2 mask readback");
        rd_chk(8'd2, 8'h34, "R2 lo readback");
        rd_chk(8'd3, 8'h12, "R2 hi readback");
        rd_chk(8'd0, 8'h01, "R2 mode readback");
        step(1'b1, 16'h1234, 1'b0, 1'b0, 8'h0, 8'h0, 1'b0, 1'b1, "R3 fetch match");
        step(1'b1, 16'h1235, 1'b0, 1'b0, 8'h0, 8'h0, 1'b0, 1'b0, "R3 fetch mismatch");
        step(1'b0, 16'h1234, 1'b0, 1'b0, 8'h0, 8'h0, 1'b0, 1'b0, "R3 fetch not valid");
        step(1'b0, 16'h0, 1'b1, 1'b0, 8'h34, 8'h12, 1'b0, 1'b0, "R3 memory ignored in fetch mode");

        // R4 address match with read qualifier, R7 read flag
        set_reg(8'd2, 8'h40);
        set_reg(8'd0, 8'h12);
        step(1'b0, 16'h0, 1'b1, 1'b1, 8'h40, 8'h00, 1'b0, 1'b0, "R4 write with read qualifier");
        step(1'b0, 16'h0, 1'b1, 1'b0, 8'h41, 8'h00, 1'b0, 1'b0, "R4 read other address");
        step(1'b0, 16'h0, 1'b0, 1'b0, 8'h40, 8'h00, 1'b0, 1'b0, "R4 no strobe");
        rd_chk(8'd0, 8'h12, "R7 no flag before trap");
        step(1'b0, 16'h0, 1'b1, 1'b0, 8'h40, 8'h00, 1'b0, 1'b1, "R4 read address trap");
        idle("R10 single cycle pulse");
        rd_chk(8'd0, 8'h52, "R7 read flag set");
        set_reg(8'd0, 8'h0A);
        rd_chk(8'd0, 8'h0A, "R7 flag cleared by mode write");
        step(1'b0, 16'h0, 1'b1, 1'b0, 8'h40, 8'h00, 1'b0, 1'b0, "R4 read with write qualifier");
        step(1'b0, 16'h0, 1'b1, 1'b1, 8'h40, 8'h00, 1'b0, 1'b1, "R4 write address trap");
        step(1'b0, 16'h0, 1'b1, 1'b1, 8'h40, 8'h00, 1'b0, 1'b1, "R10 back to back trap");
        idle("R10 pulse ends");
        rd_chk(8'd0, 8'h2A, "R7 write flag set");
        set_reg(8'd0, 8'h1A);
        step(1'b0, 16'h0, 1'b1, 1'b0, 8'h40, 8'h00, 1'b0, 1'b1, "R4 either read");
        step(1'b0, 16'h0, 1'b1, 1'b1, 8'h40, 8'h00, 1'b0, 1'b1, "R4 either write");
        rd_chk(8'd0, 8'h7A, "R7 both flags sticky");

        // R5 masked data match
        set_reg(8'd1, 8'h0F);
        set_reg(8'd3, 8'h05);
        set_reg(8'd0, 8'h14);
        step(1'b0, 16'h0, 1'b1, 1'b0, 8'h99, 8'hA5, 1'b0, 1'b1, "R5 masked data match");
        step(1'b0, 16'h0, 1'b1, 1'b0, 8'h99, 8'hA6, 1'b0, 1'b0, "R5 data mismatch");
        step(1'b0, 16'h0, 1'b1, 1'b1, 8'h99, 8'h05, 1'b0, 1'b0, "R5 write with read qualifier");
        set_reg(8'd1, 8'hFF);
        step(1'b0, 16'h0, 1'b1, 1'b0, 8'h99, 8'hA5, 1'b0, 1'b0, "R5 full mask rejects");

        // R6 address and data both required
        set_reg(8'd0, 8'h1E);
        step(1'b0, 16'h0, 1'b1, 1'b1, 8'h40, 8'h05, 1'b0, 1'b1, "R6 both match");
        step(1'b0, 16'h0, 1'b1, 1'b1, 8'h41, 8'h05, 1'b0, 1'b0, "R6 address wrong");
        step(1'b0, 16'h0, 1'b1, 1'b0, 8'h40, 8'h06, 1'b0, 1'b0, "R6 data wrong");

        // R8 single step
        set_reg(8'd0, 8'h80);
        rd_chk(8'd0, 8'h80, "R2 step mode readback");
        step(1'b0, 16'h0, 1'b0, 1'b0, 8'h0, 8'h0, 1'b1, 1'b1, "R8 step pulse");
        step(1'b0, 16'h0, 1'b0, 1'b0, 8'h0, 8'h0, 1'b1, 1'b1, "R8 second step");
        step(1'b1, 16'h1234, 1'b1, 1'b1, 8'h40, 8'h05, 1'b0, 1'b0, "R8 no strobe no pulse");
        step(1'b0, 16'h0, 1'b0, 1'b0, 8'h0, 8'h0, 1'b1, 1'b1, "R8 third step");

        // R9 disabled
        set_reg(8'd0, 8'h00);
        step(1'b1, 16'h1234, 1'b1, 1'b1, 8'h40, 8'h05, 1'b1, 1'b0, "R9 off write");
        step(1'b1, 16'h1234, 1'b1, 1'b0, 8'h40, 8'h05, 1'b1, 1'b0, "R9 off read");
        rd_chk(8'd0, 8'h00, "R9 no flags when off");
        idle("R10 final idle");
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule